// File: doc/BRIEF.md
# MDIO Management Master

This block lets software reach external PHY management registers through a small 32-bit register window. Software writes one packed command word that carries the PHY address, the register address, the operation and, for a write, the data. It then polls two status flags and, after a read, collects the 16-bit result together with an error indication. The block turns each accepted command into one serial management frame on the MDC/MDIO pins. The MDC rate comes from a programmable half-period prescaler.

Only one command can wait at a time. The pending flag shows that a command is held but not yet started. The busy flag shows that a frame is on the wire. A command slot is free again as soon as the frame engine takes the held command, so software can queue the next command while a frame is still being sent.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Register reads are combinational and decode the byte offset on `bus_addr`. Offset 0x00 is status, with bit 2 = pending and bit 3 = busy. Offset 0x0C is read data. Offset 0x10 is configuration. Every other offset reads as zero.
- R2: A write to offset 0x08 is accepted when pending is low, bit 31 is set and exactly one of bit 1 (write) and bit 2 (read) is set. The fields are PHY address in bits 29:25, register address in bits 24:20 and write data in bits 19:4. Pending reads 1 in the cycle after the accepting edge.
- R3: A command word is discarded if bit 31 is clear, or if bits 1 and 2 are both set, or if both are clear. Pending stays 0 and no frame starts.
- R4: A command write that arrives while pending is high is ignored. The held command is the only one that runs next.
- R5: While the engine is idle, it takes a pending command on the next clock edge. Pending drops and busy rises together, and busy then stays high for exactly 128×(prescale+1) cycles.
- R6: The prescale value sits in bits 7:0 of offset 0x10 and resets to 4. A write of 0 to it is ignored. Each MDC half period lasts prescale+1 clocks, and MDC is low whenever busy is low.
- R7: Each frame is 64 bits, sent most significant bit first. The sequence is 32 ones, then 01, then the opcode (10 = read, 01 = write), then the PHY address, then the register address, then a 2-bit turnaround (10 for a write), then 16 data bits. MDIO output changes only on the falling edge of MDC.
- R8: Output enable is high for the whole of a write frame and for the first 46 bits of a read frame. It is low for the turnaround and data bits of a read, and low when idle.
- R9: A read samples MDIO on the rising edge of MDC. The 16 data bits appear MSB first in bits 15:0 of offset 0x0C.
- R10: If MDIO is not low in the second turnaround bit of a read, bits 17:16 of offset 0x0C both read 1. These bits and the data bits are cleared only when the next read frame starts. A write frame leaves them unchanged.
- R11: After reset, status reads 0, configuration reads 4, and MDC, output enable and read data are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Register byte offset |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
Register reads are combinational, so the bench samples them just after a falling clock edge. A command written at one rising edge shows as pending at the next falling edge, and as busy with pending clear one cycle after that. The bench then counts busy cycles and requires exactly 128×(prescale+1) of them. The PHY model captures MDIO one time unit after each MDC rise and drives its reply one unit after each MDC fall, so every bit is stable for a whole half period before the block samples it. Read data and error bits are checked only once busy has dropped.

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
  parameter logic [7:0] PRESCALE_RST = 8'd4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FRAME_BITS = 64;
  localparam int TA_BIT     = 46;
  localparam int DATA_BIT   = 48;
  localparam logic [5:0] LAST_BIT = 6'(FRAME_BITS - 1);

  logic [7:0]  prescale, cnt;
  logic        pending, busy, op_rd, rd_err;
  logic        cmd_rd;
  logic [4:0]  cmd_phy, cmd_reg;
  logic [15:0] cmd_wd, rd_data;
  logic [FRAME_BITS-1:0] sh;
  logic [5:0]  bit_idx;

  wire cmd_wr = bus_we && bus_addr == 5'h08;
  wire cmd_ok = bus_wdata[31] && (bus_wdata[1] ^ bus_wdata[2]);
  wire cfg_wr = bus_we && bus_addr == 5'h10 && bus_wdata[7:0] != 8'd0;
  wire tick   = busy && cnt >= prescale;

  assign mdio_o  = busy & sh[FRAME_BITS-1];
  assign mdio_oe = busy & ~(op_rd & bit_idx >= 6'(TA_BIT));

  always_comb begin
    case (bus_addr)
      5'h00:   bus_rdata = {28'd0, busy, pending, 2'b00};
      5'h0C:   bus_rdata = {14'd0, {2{rd_err}}, rd_data};
      5'h10:   bus_rdata = {24'd0, prescale};
      default: bus_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prescale <= PRESCALE_RST;
      pending  <= 1'b0;
      busy     <= 1'b0;
      op_rd    <= 1'b0;
      cmd_rd   <= 1'b0;
      cmd_phy  <= '0;
      cmd_reg  <= '0;
      cmd_wd   <= '0;
      sh       <= '0;
      bit_idx  <= '0;
      cnt      <= '0;
      mdc      <= 1'b0;
      rd_data  <= '0;
      rd_err   <= 1'b0;
    end else begin
      if (cfg_wr) prescale <= bus_wdata[7:0];

      if (cmd_wr && !pending && cmd_ok) begin
        pending <= 1'b1;
        cmd_rd  <= bus_wdata[2];
        cmd_phy <= bus_wdata[29:25];
        cmd_reg <= bus_wdata[24:20];
        cmd_wd  <= bus_wdata[19:4];
      end else if (pending && !busy) begin
        pending <= 1'b0;
        busy    <= 1'b1;
        op_rd   <= cmd_rd;
        bit_idx <= '0;
        cnt     <= '0;
        mdc     <= 1'b0;
        sh      <= {32'hFFFF_FFFF, 2'b01, cmd_rd ? 2'b10 : 2'b01, cmd_phy, cmd_reg,
                    cmd_rd ? 2'b11 : 2'b10, cmd_rd ? 16'hFFFF : cmd_wd};
        if (cmd_rd) begin
          rd_data <= '0;
          rd_err  <= 1'b0;
        end
      end

      if (busy) begin
        if (tick) begin
          cnt <= '0;
          mdc <= ~mdc;
          if (!mdc) begin
            if (op_rd && bit_idx == 6'(TA_BIT + 1) && mdio_i) rd_err <= 1'b1;
            if (op_rd && bit_idx >= 6'(DATA_BIT)) rd_data <= {rd_data[14:0], mdio_i};
          end else if (bit_idx == LAST_BIT) begin
            busy <= 1'b0;
          end else begin
            bit_idx <= bit_idx + 6'd1;
            sh      <= {sh[FRAME_BITS-2:0], 1'b1};
          end
        end else begin
          cnt <= cnt + 8'd1;
        end
      end
    end
  end

  AST_TAKE_CMD:     assert property (@(posedge clk) disable iff (!rst_n) pending && !busy |=> busy && !pending); // R5
  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mdc); // R6
  AST_MDC_HOLD:     assert property (@(posedge clk) disable iff (!rst_n) busy && cnt < prescale |=> $stable(mdc)); // R6
  AST_PRESCALE_NZ:  assert property (@(posedge clk) disable iff (!rst_n) prescale != 8'd0); // R6
  AST_CMD_HELD:     assert property (@(posedge clk) disable iff (!rst_n) pending && cmd_wr |=> $stable({cmd_rd, cmd_phy, cmd_reg, cmd_wd})); // R4
  AST_END_RELEASE:  assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> !mdio_oe && !mdc); // R8
endmodule

// File: tb/tb_mdio_mgmt_master.sv
module tb_mdio_mgmt_master;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  mdio_mgmt_master dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, frames = 0, n = 0, cyc = 0;
  logic [63:0] cap, oe_cap;
  logic        cur_rd = 1'b0, phy_ok = 1'b1;
  logic [15:0] phy_val = '0;
  logic [7:0]  pre = 8'd4;
  logic        err_prev = 1'b0;
  logic [15:0] data_prev = '0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(logic rd, logic [4:0] phy, logic [4:0] rg, logic [15:0] wd);
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg, rd ? 2'b11 : 2'b10, rd ? 16'hFFFF : wd};
  endfunction

  function automatic logic [31:0] cmd_word(logic v, logic rd, logic wr, logic [4:0] phy, logic [4:0] rg, logic [15:0] wd);
    return {v, 1'b0, phy, rg, wd, 1'b0, rd, wr, 1'b0};
  endfunction

  always @(posedge mdio_oe) begin n = 0; frames++; end
  always @(posedge mdc) begin
    #1;
    if (n < 64) begin cap[63-n] = mdio_o; oe_cap[63-n] = mdio_oe; end
    n++;
  end
  always @(negedge mdc) begin
    #1;
    if (cur_rd && n == 47) mdio_i = !phy_ok;
    else if (cur_rd && phy_ok && n >= 48 && n < 64) mdio_i = phy_val[63-n];
    else mdio_i = 1'b1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL R5 watchdog actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic bus_wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd_reg(logic [4:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    do begin @(negedge clk); rd_reg(5'h00, s); end while (s[3] || s[2]);
  endtask

  task automatic txn(logic rd, logic [4:0] phy, logic [4:0] rg, logic [15:0] wd, logic ok, logic [15:0] rv);
    logic [31:0] s;
    int busy_cyc = 0;
    cur_rd = rd; phy_ok = ok; phy_val = rv;
    bus_wr(5'h08, cmd_word(1'b1, rd, !rd, phy, rg, wd));
    rd_reg(5'h00, s);
    chk("R2 pending after accept", s[3:2], 2'b01);
    @(negedge clk); rd_reg(5'h00, s);
    chk("R5 engine takes command", s[3:2], 2'b10);
    while (s[3]) begin busy_cyc++; @(negedge clk); rd_reg(5'h00, s); end
    chk("R5 R6 busy length", busy_cyc, 128 * (int'(pre) + 1));
    chk("R6 mdc low when idle", mdc, 1'b0);
    if (rd) begin
      chk("R7 read frame", cap[63:18], exp_frame(1'b1, phy, rg, wd) >> 18);
      chk("R8 oe read frame", oe_cap, {46'h3FFF_FFFF_FFFF, 18'd0});
      rd_reg(5'h0C, s);
      chk("R9 R10 read data", s, ok ? {16'd0, rv} : 32'h0003_FFFF);
      err_prev = !ok; data_prev = ok ? rv : 16'hFFFF;
    end else begin
      chk("R7 write frame", cap, exp_frame(1'b0, phy, rg, wd));
      chk("R8 oe write frame", oe_cap, 64'hFFFF_FFFF_FFFF_FFFF);
      rd_reg(5'h0C, s);
      chk("R10 write keeps data", s, {14'd0, {2{err_prev}}, data_prev});
    end
  endtask

  initial begin
    logic [31:0] s;
    int f0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_reg(5'h00, s); chk("R11 status reset", s, 32'd0);
    rd_reg(5'h10, s); chk("R11 R6 prescale reset", s, 32'd4);
    rd_reg(5'h0C, s); chk("R11 data reset", s, 32'd0);
    chk("R11 pins reset", {mdc, mdio_oe}, 2'b00);
    rd_reg(5'h04, s); chk("R1 unmapped offset", s, 32'd0);

    bus_wr(5'h10, 32'd0);
    rd_reg(5'h10, s); chk("R6 prescale zero ignored", s, 32'd4);
    bus_wr(5'h10, 32'd1); pre = 8'd1;
    rd_reg(5'h10, s); chk("R1 R6 prescale write", s, 32'd1);

    f0 = frames;
    bus_wr(5'h08, cmd_word(1'b0, 1'b1, 1'b0, 5'd3, 5'd2, 16'h1234));
    rd_reg(5'h00, s); chk("R3 no valid", s[3:2], 2'b00);
    bus_wr(5'h08, cmd_word(1'b1, 1'b1, 1'b1, 5'd3, 5'd2, 16'h1234));
    rd_reg(5'h00, s); chk("R3 both ops", s[3:2], 2'b00);
    bus_wr(5'h08, cmd_word(1'b1, 1'b0, 1'b0, 5'd3, 5'd2, 16'h1234));
    rd_reg(5'h00, s); chk("R3 no op", s[3:2], 2'b00);
    repeat (50) @(negedge clk);
    chk("R3 no frame started", frames - f0, 0);
    chk("R3 mdc idle", mdc, 1'b0);

    txn(1'b1, 5'h1F, 5'h00, 16'h0, 1'b1, 16'h8001);
    txn(1'b0, 5'h00, 5'h1F, 16'hFFFF, 1'b1, 16'h0);
    txn(1'b1, 5'h05, 5'h0A, 16'h0, 1'b0, 16'h0);
    txn(1'b0, 5'h11, 5'h04, 16'hA5C3, 1'b1, 16'h0);
    txn(1'b1, 5'h05, 5'h0A, 16'h0, 1'b1, 16'h0000);

    for (int i = 0; i < 16; i++) begin
      pre = 8'($urandom_range(1, 3));
      bus_wr(5'h10, {24'd0, pre});
      txn(1'($urandom_range(0, 1)), 5'($urandom), 5'($urandom), 16'($urandom),
          $urandom_range(0, 3) != 0, 16'($urandom));
    end

    f0 = frames;
    cur_rd = 1'b0;
    bus_wr(5'h08, cmd_word(1'b1, 1'b0, 1'b1, 5'd1, 5'd1, 16'h1111));
    repeat (4) @(negedge clk);
    cur_rd = 1'b1; phy_ok = 1'b1; phy_val = 16'h5A3C;
    bus_wr(5'h08, cmd_word(1'b1, 1'b1, 1'b0, 5'd9, 5'd7, 16'h0));
    rd_reg(5'h00, s); chk("R4 queued while busy", s[3:2], 2'b11);
    bus_wr(5'h08, cmd_word(1'b1, 1'b0, 1'b1, 5'd2, 5'd3, 16'hBEEF));
    wait_idle();
    repeat (300) @(negedge clk);
    chk("R4 only two frames", frames - f0, 2);
    chk("R4 held command ran", cap[63:18], exp_frame(1'b1, 5'd9, 5'd7, 16'h0) >> 18);
    rd_reg(5'h0C, s); chk("R9 queued read data", s, 32'h0000_5A3C);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule